// File: doc/BRIEF.md
# Line Interface Loopback Selector

This block sits in one channel of a line interface, between the system-side transmit and receive ports and the line-side encoder and decoder paths. It steers each bit between four routings: normal pass-through, local loopback (system transmit turned back toward the system receive port), line loopback (recovered line data turned back toward the line), and both loopbacks at once. In the local loopback the transmit bit still goes to the line. In the line loopback the recovered bit still goes to the system.

Bits travel as data words qualified by single-cycle strobes on one core clock. The system transmit strobe and the recovered receive strobe stand in for the two bit clocks. Each output register takes a whole bit from its chosen source when that source strobes, and holds it in between. Mode changes and all-ones overrides therefore act only at bit boundaries.

The loss-of-signal flag is honoured in every routing. With the matching enable set, it forces all ones onto the system receive output (alarm indication) and onto the line transmit output (automatic transmit all ones). The five mode requests are decoded by a fixed priority. Analog and inband loopback are mode codes only: analog routes like digital, and inband routes like remote.

Top module: `lb_selector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, both output strobes are 0 and both output data words are 0.
- R2: With no mode request, a sys_tx_stb bit appears on line_tx one cycle later, and a line_rx_stb bit appears on sys_rx one cycle later.
- R3: With req_digital or req_analog winning, sys_rx takes the sys_tx bit and strobe. line_tx still takes the sys_tx bit. line_rx input is ignored.
- R4: With req_remote or req_inband winning, line_tx takes the line_rx bit and strobe. sys_rx still takes the line_rx bit. sys_tx input is ignored.
- R5: With req_dual winning, line_tx takes the line_rx bit and sys_rx takes the sys_tx bit, each with its own strobe.
- R6: When several requests are set, the winner is chosen in the order dual, remote, digital, analog, inband (highest first).
- R7: When los and ais_en are both 1 at a strobe of sys_rx's source, the sys_rx bit written is all ones. This holds in every mode.
- R8: When los and atao_en are both 1 at a strobe of line_tx's source, the line_tx bit written is all ones. This holds in every mode.
- R9: ais_en and atao_en have no effect while los is 0, and los has no effect while both enables are 0.
- R10: An output data word changes only in a cycle where its strobe is 1. A mode, los or enable change without a source strobe leaves both outputs unchanged.
- R11: An output strobe pulses only one cycle after a strobe of its selected source. A strobe on the unselected source produces no output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tx_data | input | W | System transmit bit |
| sys_tx_stb | input | 1 | System transmit bit strobe |
| line_rx_data | input | W | Recovered line receive bit |
| line_rx_stb | input | 1 | Recovered line receive bit strobe |
| los | input | 1 | Loss-of-signal flag from the detector |
| req_dual | input | 1 | Dual loopback request |
| req_remote | input | 1 | Remote (line) loopback request |
| req_digital | input | 1 | Digital (local) loopback request |
| req_analog | input | 1 | Analog loopback request, routed like digital |
| req_inband | input | 1 | Inband loopback request, routed like remote |
| ais_en | input | 1 | All-ones on system receive during los |
| atao_en | input | 1 | All-ones on line transmit during los |
| line_tx_data | output | W | Bit toward the line encoder |
| line_tx_stb | output | 1 | Line transmit bit strobe |
| sys_rx_data | output | W | Bit toward the system receive port |
| sys_rx_stb | output | 1 | System receive bit strobe |

## Verification
The bench drives both sources at once with opposite data. A design that swaps a routing or lets an ignored input leak through then shows the wrong bit on at least one output. Mixed requests are tested in pairs whose winners route differently, so a wrong priority order shows up as a different bit. Strobes are also sent on only one source per loopback mode. This catches a design that emits a spurious strobe from the unselected side. Mode and los changes are applied with no strobe present, which exposes an override or mode switch that cuts into a bit rather than waiting for the next one.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef enum logic [2:0] {
    MS_NONE    = 3'd0,
    MS_DUAL    = 3'd1,
    MS_REMOTE  = 3'd2,
    MS_DIGITAL = 3'd3,
    MS_ANALOG  = 3'd4,
    MS_INBAND  = 3'd5
  } mode_win_t;

  typedef enum logic [1:0] {
    RT_NORMAL = 2'd0,
    RT_LOCAL  = 2'd1,
    RT_LINE   = 2'd2,
    RT_DUAL   = 2'd3
  } route_t;

  // Fixed priority among the requests: dual > remote > digital > analog > inband
  function automatic mode_win_t pick_winner(input logic dual, input logic remote,
                                            input logic digital, input logic analog,
                                            input logic inband);
    if (dual)         return MS_DUAL;
    else if (remote)  return MS_REMOTE;
    else if (digital) return MS_DIGITAL;
    else if (analog)  return MS_ANALOG;
    else if (inband)  return MS_INBAND;
    else              return MS_NONE;
  endfunction

  function automatic route_t route_of(input mode_win_t w);
    case (w)
      MS_DUAL:               return RT_DUAL;
      MS_REMOTE, MS_INBAND:  return RT_LINE;
      MS_DIGITAL, MS_ANALOG: return RT_LOCAL;
      default:               return RT_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/lb_mode_decode.sv
module lb_mode_decode
  import lb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_dual,
  input  logic req_remote,
  input  logic req_digital,
  input  logic req_analog,
  input  logic req_inband,
  output logic tx_from_line,
  output logic rx_from_sys
);

  mode_win_t winner;
  route_t    route;

  assign winner       = pick_winner(req_dual, req_remote, req_digital, req_analog, req_inband);
  assign route        = route_of(winner);
  assign tx_from_line = (route == RT_LINE) || (route == RT_DUAL);
  assign rx_from_sys  = (route == RT_LOCAL) || (route == RT_DUAL);

  // R6: a dual request always turns both directions around
  assert_dual_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_dual |-> (tx_from_line && rx_from_sys));

  // R6: remote beats digital and analog
  assert_remote_over_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_remote && !req_dual) |-> (tx_from_line && !rx_from_sys));

  // R4: inband alone behaves as a line loopback
  assert_inband_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (winner == MS_INBAND) |-> (tx_from_line && !rx_from_sys));

endmodule

// File: rtl/lb_dir_path.sv
module lb_dir_path #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_data,
  input  logic         a_stb,
  input  logic [W-1:0] b_data,
  input  logic         b_stb,
  input  logic         sel_b,
  input  logic         force_ones,
  output logic [W-1:0] out_data,
  output logic         out_stb
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic         chosen_stb;
  logic [W-1:0] chosen_data;
  logic [W-1:0] next_bit;

  assign chosen_stb  = sel_b ? b_stb  : a_stb;
  assign chosen_data = sel_b ? b_data : a_data;
  assign next_bit    = force_ones ? ALL_ONES : chosen_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_stb  <= 1'b0;
    end else begin
      out_stb <= chosen_stb;
      if (chosen_stb) out_data <= next_bit;
    end
  end

  // R10: the bit word only moves at a bit boundary
  assert_hold_between_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |-> $stable(out_data));

  // R11: every output strobe traces back to the selected source
  assert_strobe_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> $past(sel_b ? b_stb : a_stb));

  // R7 and R8: an override present at the boundary yields all ones
  assert_force_ones_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && $past(force_ones)) |-> (out_data == ALL_ONES));

endmodule

// File: rtl/lb_selector.sv
module lb_selector
  import lb_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sys_tx_data,
  input  logic         sys_tx_stb,
  input  logic [W-1:0] line_rx_data,
  input  logic         line_rx_stb,
  input  logic         los,
  input  logic         req_dual,
  input  logic         req_remote,
  input  logic         req_digital,
  input  logic         req_analog,
  input  logic         req_inband,
  input  logic         ais_en,
  input  logic         atao_en,
  output logic [W-1:0] line_tx_data,
  output logic         line_tx_stb,
  output logic [W-1:0] sys_rx_data,
  output logic         sys_rx_stb
);

  logic tx_from_line;
  logic rx_from_sys;
  logic ais_force;
  logic atao_force;

  assign ais_force  = los && ais_en;
  assign atao_force = los && atao_en;

  lb_mode_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_dual     (req_dual),
    .req_remote   (req_remote),
    .req_digital  (req_digital),
    .req_analog   (req_analog),
    .req_inband   (req_inband),
    .tx_from_line (tx_from_line),
    .rx_from_sys  (rx_from_sys)
  );

  // toward the line: system transmit normally, recovered data when looped at the line
  lb_dir_path #(.W(W)) u_tx_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_data     (sys_tx_data),
    .a_stb      (sys_tx_stb),
    .b_data     (line_rx_data),
    .b_stb      (line_rx_stb),
    .sel_b      (tx_from_line),
    .force_ones (atao_force),
    .out_data   (line_tx_data),
    .out_stb    (line_tx_stb)
  );

  // toward the system: recovered data normally, system transmit when looped locally
  lb_dir_path #(.W(W)) u_rx_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_data     (line_rx_data),
    .a_stb      (line_rx_stb),
    .b_data     (sys_tx_data),
    .b_stb      (sys_tx_stb),
    .sel_b      (rx_from_sys),
    .force_ones (ais_force),
    .out_data   (sys_rx_data),
    .out_stb    (sys_rx_stb)
  );

  // R5: in dual loopback each direction follows its own source strobe
  assert_dual_rx_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dual && sys_tx_stb) |=> sys_rx_stb);

  assert_dual_tx_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dual && line_rx_stb) |=> line_tx_stb);

  // R2: with no request, each direction passes straight through
  assert_normal_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_dual && !req_remote && !req_digital && !req_analog && !req_inband
     && sys_tx_stb) |=> line_tx_stb);

  // R9: without los the line bit is never forced
  assert_no_force_without_los_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && !tx_from_line && sys_tx_stb) |=> (line_tx_data == $past(sys_tx_data)));

endmodule

// File: tb/tb_lb_selector.sv
module tb_lb_selector;

  localparam int W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] sys_tx_data = '0;
  logic sys_tx_stb = 1'b0;
  logic [W-1:0] line_rx_data = '0;
  logic line_rx_stb = 1'b0;
  logic los = 1'b0;
  logic req_dual = 1'b0, req_remote = 1'b0, req_digital = 1'b0;
  logic req_analog = 1'b0, req_inband = 1'b0;
  logic ais_en = 1'b0, atao_en = 1'b0;
  logic [W-1:0] line_tx_data;
  logic line_tx_stb;
  logic [W-1:0] sys_rx_data;
  logic sys_rx_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lb_selector #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .sys_tx_data(sys_tx_data), .sys_tx_stb(sys_tx_stb),
    .line_rx_data(line_rx_data), .line_rx_stb(line_rx_stb),
    .los(los),
    .req_dual(req_dual), .req_remote(req_remote), .req_digital(req_digital),
    .req_analog(req_analog), .req_inband(req_inband),
    .ais_en(ais_en), .atao_en(atao_en),
    .line_tx_data(line_tx_data), .line_tx_stb(line_tx_stb),
    .sys_rx_data(sys_rx_data), .sys_rx_stb(sys_rx_stb)
  );

  // [15:11] dual,remote,digital,analog,inband [10] los [9] ais_en [8] atao_en
  // [7] sys_tx_data [6] sys_tx_stb [5] line_rx_data [4] line_rx_stb
  // [3] exp line_tx_stb [2] exp line_tx_data [1] exp sys_rx_stb [0] exp sys_rx_data
  localparam int NV = 24;
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'b00000_000_1101_1110, // R2 normal
    16'b00000_000_0111_1011, // R2 normal, swapped data
    16'b00100_000_1101_1111, // R3 digital
    16'b00100_000_0111_1010, // R3 digital, swapped
    16'b00010_000_1101_1111, // R3 analog
    16'b01000_000_1101_1010, // R4 remote
    16'b01000_000_0111_1111, // R4 remote, swapped
    16'b00001_000_1101_1010, // R4 inband
    16'b10000_000_1101_1011, // R5 dual
    16'b10000_000_0111_1110, // R5 dual, swapped
    16'b11111_000_1101_1011, // R6 all set: dual
    16'b01100_000_1101_1010, // R6 remote over digital
    16'b00101_000_1101_1111, // R6 digital over inband
    16'b00011_000_1101_1111, // R6 analog over inband
    16'b00000_110_0101_1011, // R7 ais during los
    16'b00000_101_0101_1110, // R8 atao during los
    16'b00000_100_0101_1010, // R9 los, no enables
    16'b00000_011_0101_1010, // R9 enables, no los
    16'b00100_111_0101_1111, // R7 digital loop with los
    16'b01000_101_0101_1110, // R8 remote loop with los
    16'b00000_000_1110_1100, // R11 normal, sys strobe only
    16'b01000_000_1110_0000, // R11 remote, sys strobe ignored
    16'b00100_000_0011_0000, // R11 digital, line strobe ignored
    16'b10000_000_0011_1100  // R11 dual, line strobe only
  };

  function automatic string tag_of(input int i);
    if (i < 2)       return "R2";
    else if (i < 5)  return (i == 4) ? "R3 analog" : "R3";
    else if (i < 8)  return "R4";
    else if (i < 10) return "R5";
    else if (i < 14) return "R6";
    else if (i == 14 || i == 18) return "R7";
    else if (i == 15 || i == 19) return "R8";
    else if (i < 18) return "R9";
    else             return "R11";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] v);
    {req_dual, req_remote, req_digital, req_analog, req_inband} = v[15:11];
    los = v[10]; ais_en = v[9]; atao_en = v[8];
    sys_tx_data = v[7]; sys_tx_stb = v[6];
    line_rx_data = v[5]; line_rx_stb = v[4];
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, strobes active on inputs while held
    sys_tx_stb = 1'b1; line_rx_stb = 1'b1; sys_tx_data = 1'b1; line_rx_data = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 line_tx_stb", line_tx_stb, 0);
    check("R1 line_tx_data", line_tx_data, 0);
    check("R1 sys_rx_stb", sys_rx_stb, 0);
    check("R1 sys_rx_data", sys_rx_data, 0);
    sys_tx_stb = 1'b0; line_rx_stb = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release line_tx_stb", line_tx_stb, 0);
    check("R1 after release sys_rx_stb", sys_rx_stb, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check({tag_of(i), " line_tx_stb"}, line_tx_stb, VEC[i][3]);
      check({tag_of(i), " sys_rx_stb"}, sys_rx_stb, VEC[i][1]);
      if (VEC[i][3]) check({tag_of(i), " line_tx_data"}, line_tx_data, VEC[i][2]);
      if (VEC[i][1]) check({tag_of(i), " sys_rx_data"}, sys_rx_data, VEC[i][0]);
    end

    // R10: load known bits, then change mode and los with no strobes
    drive(16'b00000_000_1111_0000);
    @(negedge clk);
    check("R10 setup line_tx_data", line_tx_data, 1);
    check("R10 setup sys_rx_data", sys_rx_data, 1);
    drive(16'b01000_000_0000_0000);
    sys_tx_stb = 1'b0; line_rx_stb = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 mode change line_tx_data", line_tx_data, 1);
    check("R10 mode change line_tx_stb", line_tx_stb, 0);
    drive(16'b00000_000_0000_0000);
    @(negedge clk);
    drive(16'b00000_000_0101_0000); // zeros into both outputs
    @(negedge clk);
    drive(16'b00000_111_0000_0000); // los with both overrides, no strobe
    repeat (2) @(negedge clk);
    check("R10 los no strobe sys_rx_data", sys_rx_data, 0);
    check("R10 los no strobe line_tx_data", line_tx_data, 0);
    check("R10 los no strobe sys_rx_stb", sys_rx_stb, 0);
    // next bit boundary picks up the override
    drive(16'b00000_111_0101_0000);
    @(negedge clk);
    check("R7 boundary sys_rx_data", sys_rx_data, 1);
    check("R8 boundary line_tx_data", line_tx_data, 1);

    drive(16'b00000_000_0000_0000);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule